// File: doc/BRIEF.md
# Auto-Reload Interval Timer

An 8-bit binary down-counter with a reload register, used as a periodic interval source. On each enable pulse from the selected count source the counter steps down by one. When a pulse arrives while the counter already holds zero, the block raises an interrupt request flag, emits a one-cycle underflow strobe for neighbouring timers and reloads the counter from the reload register. With reload value n the strobe therefore appears once every n + 1 source pulses.

A host write port carries a two-bit command and a data byte. The commands load counter and reload register together, load only the reload register, write the control register, or clear the interrupt flag. The live count is always visible on an output. The control register picks one of four count sources, holds the run bit, and can put the timer into trigger-start mode. In that mode a rising edge on an asynchronous trigger pin, after synchronization, starts the count. With auto-stop also set, the timer halts on its first underflow and waits for the next trigger edge.

Top module: `reload_down_timer`

## Requirements
- R1: After reset the count and reload value are 0, and `irq_flag`, `uf_pulse` and `running` are all 0.
- R2: Command 0 writes `host_wdata` into both the counter and the reload register, visible on `count_out` one clock later. Command 1 writes only the reload register: `count_out` is unchanged, and the new value is loaded at the next underflow.
- R3: With reload value n and the counter started from n, `uf_pulse` fires on every (n + 1)-th selected source pulse and on no other one. This includes n = 0, where every pulse underflows.
- R4: A source pulse taken while the count is 0 reloads the counter and sets `irq_flag` on the same clock. It also raises `uf_pulse` for exactly one cycle.
- R5: Command 2 writes the control byte. Bits [1:0] select which `src_pulse` line counts, bit 2 is run, bit 3 is trigger-start mode and bit 4 is auto-stop. Pulses on lines that are not selected do not change the count.
- R6: While `running` is 0, source pulses leave the count unchanged.
- R7: In trigger-start mode the run bit alone does not start counting. A rising edge on `ext_trig` sets `running` on the third clock edge after the pin rises: two synchronizer stages, then the state register.
- R8: In trigger-start mode with auto-stop set, an underflow clears `running` and the counter holds the reloaded value. A later rising edge on `ext_trig` starts it again.
- R9: Command 3 with `host_wdata[0]`=1 clears `irq_flag`; with bit 0 at 0 it has no effect. An underflow in the same cycle as a clear leaves the flag set.
- R10: A command-0 load in the same cycle as a counting pulse takes priority. The counter takes the written value and no underflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pulse | input | 4 | Single-cycle count enable pulses, one per source |
| ext_trig | input | 1 | Asynchronous start trigger pin |
| host_wr | input | 1 | Host write strobe |
| host_cmd | input | 2 | 0 load both, 1 load reload, 2 control, 3 clear flag |
| host_wdata | input | 8 | Host write data |
| count_out | output | 8 | Live counter value |
| irq_flag | output | 1 | Interrupt request flag, write-1-to-clear |
| uf_pulse | output | 1 | One-cycle underflow strobe |
| running | output | 1 | Timer is counting |

## Verification
The bench writes a new reload value while a count is in progress. A design that reloaded from a stale copy would show the old value after underflow. It also checks the zero-reload case, where a design that decrements before testing for zero would wrap to 255 instead of staying at zero. The bench clears the flag in the same cycle as an underflow and loads the counter in the same cycle as a count pulse, which catches a wrong priority in either case. It measures the trigger start latency to the exact clock. It also checks that an auto-stopped timer stays frozen until a fresh edge, which exposes a missing synchronizer stage or a missing stop.

// File: rtl/rdt_pkg.sv
// Shared definitions for the auto-reload interval timer.
// Assumes the control byte layout below is what host software writes.
package rdt_pkg;
    localparam int SEL_W  = 2;
    localparam int CTRL_W = SEL_W + 3;

    typedef enum logic [1:0] {
        CMD_LOAD_BOTH   = 2'd0,
        CMD_LOAD_RELOAD = 2'd1,
        CMD_CTRL        = 2'd2,
        CMD_CLR_FLAG    = 2'd3
    } host_cmd_e;

    typedef struct packed {
        logic             auto_stop;
        logic             trig_start;
        logic             run;
        logic [SEL_W-1:0] src_sel;
    } ctrl_t;
endpackage

// File: rtl/rdt_trig_sync.sv
// Brings the asynchronous trigger pin into the clock domain through
// STAGES flops and flags a rising edge for one cycle.
// Assumes the pin stays at each level for at least two clocks.
module rdt_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    logic [STAGES:0] chain_q;

    // Shift the pin through the synchronizer and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], pin_i};
    end

    // Edge = synchronized level high while the previous level was low.
    always_comb rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/rdt_ctrl.sv
// Control register and run state. Decides whether the timer is
// counting and which source pulse becomes the count tick.
// Assumes uf_i is the same-cycle underflow indication from the core.
module rdt_ctrl
    import rdt_pkg::*;
#(
    parameter int NSRC = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr_i,
    input  logic [CTRL_W-1:0] ctrl_data_i,
    input  logic [NSRC-1:0]   src_pulse_i,
    input  logic              trig_rise_i,
    input  logic              uf_i,
    output logic              tick_o,
    output logic              running_o,
    output logic              stop_arm_o
);
    ctrl_t ctrl_q;
    logic  started_q;

    // Hold the control byte written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)         ctrl_q <= '0;
        else if (ctrl_wr_i) ctrl_q <= ctrl_t'(ctrl_data_i);
    end

    // Trigger-mode start state: set by an edge, cleared by auto-stop or disarm.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 started_q <= 1'b0;
        else if (!ctrl_q.run || !ctrl_q.trig_start) started_q <= 1'b0;
        else if (uf_i && ctrl_q.auto_stop)          started_q <= 1'b0;
        else if (trig_rise_i)                       started_q <= 1'b1;
    end

    // Running follows the run bit directly unless trigger-start is chosen.
    always_comb begin
        running_o  = ctrl_q.run & (ctrl_q.trig_start ? started_q : 1'b1);
        tick_o     = running_o & src_pulse_i[ctrl_q.src_sel];
        stop_arm_o = ctrl_q.trig_start & ctrl_q.auto_stop;
    end
endmodule

// File: rtl/rdt_core.sv
// Down-counter, reload register, interrupt flag and underflow strobe.
// Assumes at most one host command per cycle; a load beats a tick.
module rdt_core #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_both_i,
    input  logic             load_reload_i,
    input  logic             clr_flag_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] count_o,
    output logic             flag_o,
    output logic             uf_now_o,
    output logic             uf_pulse_o
);
    logic [WIDTH-1:0] reload_q;

    // Underflow: a tick accepted while the counter sits at zero.
    always_comb uf_now_o = tick_i & ~load_both_i & (count_o == '0);

    // Reload register written by either load command.
    always_ff @(posedge clk) begin
        if (!rst_n)                            reload_q <= '0;
        else if (load_both_i || load_reload_i) reload_q <= data_i;
    end

    // Counter: host load first, then reload on underflow, else step down.
    always_ff @(posedge clk) begin
        if (!rst_n)           count_o <= '0;
        else if (load_both_i) count_o <= data_i;
        else if (uf_now_o)    count_o <= reload_q;
        else if (tick_i)      count_o <= count_o - 1'b1;
    end

    // Interrupt flag: a set in the same cycle as a clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_o <= 1'b0;
        else if (uf_now_o)   flag_o <= 1'b1;
        else if (clr_flag_i) flag_o <= 1'b0;
    end

    // One-cycle strobe for other timers.
    always_ff @(posedge clk) begin
        if (!rst_n) uf_pulse_o <= 1'b0;
        else        uf_pulse_o <= uf_now_o;
    end
endmodule

// File: rtl/reload_down_timer.sv
// Top of the auto-reload interval timer: decodes host commands and
// wires the synchronizer, control and counter core together.
// Assumes src_pulse lines are single-cycle enables in the clk domain.
module reload_down_timer
    import rdt_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int NSRC       = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_pulse,
    input  logic             ext_trig,
    input  logic             host_wr,
    input  logic [1:0]       host_cmd,
    input  logic [WIDTH-1:0] host_wdata,
    output logic [WIDTH-1:0] count_out,
    output logic             irq_flag,
    output logic             uf_pulse,
    output logic             running
);
    logic wr_load_both, wr_load_reload, wr_ctrl, wr_clr;
    logic trig_rise, tick, uf_now, stop_arm;

    // Decode the host command into one strobe per action.
    always_comb begin
        wr_load_both   = host_wr && (host_cmd == CMD_LOAD_BOTH);
        wr_load_reload = host_wr && (host_cmd == CMD_LOAD_RELOAD);
        wr_ctrl        = host_wr && (host_cmd == CMD_CTRL);
        wr_clr         = host_wr && (host_cmd == CMD_CLR_FLAG) && host_wdata[0];
    end

    rdt_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_trig),
        .rise_o (trig_rise)
    );

    rdt_ctrl #(.NSRC(NSRC)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr_i   (wr_ctrl),
        .ctrl_data_i (host_wdata[CTRL_W-1:0]),
        .src_pulse_i (src_pulse),
        .trig_rise_i (trig_rise),
        .uf_i        (uf_now),
        .tick_o      (tick),
        .running_o   (running),
        .stop_arm_o  (stop_arm)
    );

    rdt_core #(.WIDTH(WIDTH)) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick),
        .load_both_i   (wr_load_both),
        .load_reload_i (wr_load_reload),
        .clr_flag_i    (wr_clr),
        .data_i        (host_wdata),
        .count_o       (count_out),
        .flag_o        (irq_flag),
        .uf_now_o      (uf_now),
        .uf_pulse_o    (uf_pulse)
    );
endmodule

// File: rtl/reload_down_timer_chk.sv
// Property checker for the interval timer, attached by bind.
// Assumes the default 8-bit width.
module reload_down_timer_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic [1:0]       host_cmd,
    input logic [WIDTH-1:0] host_wdata,
    input logic [WIDTH-1:0] count_out,
    input logic             irq_flag,
    input logic             uf_pulse,
    input logic             running,
    input logic             uf_now,
    input logic             stop_arm
);
    assert_load_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_cmd == 2'd0) |=> count_out == $past(host_wdata));

    assert_uf_from_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        uf_pulse |-> ($past(count_out) == '0 && irq_flag));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !(host_wr && host_cmd == 2'd0)) |=> $stable(count_out));

    assert_auto_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_now && stop_arm && !host_wr) |=> !running);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        uf_now |=> irq_flag);

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_cmd == 2'd3 && host_wdata[0] && !uf_now) |=> !irq_flag);
endmodule

bind reload_down_timer reload_down_timer_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_cmd   (host_cmd),
    .host_wdata (host_wdata),
    .count_out  (count_out),
    .irq_flag   (irq_flag),
    .uf_pulse   (uf_pulse),
    .running    (running),
    .uf_now     (uf_now),
    .stop_arm   (stop_arm)
);

// File: tb/reload_down_timer_test.sv
// Directed bench for the interval timer: one task per scenario.
module reload_down_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src = '0;
    logic       trig = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] cmd = '0;
    logic [7:0] wdata = '0;
    logic [7:0] count_out;
    logic       irq_flag, uf_pulse, running;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    reload_down_timer uut (
        .clk(clk), .rst_n(rst_n), .src_pulse(src), .ext_trig(trig),
        .host_wr(wr), .host_cmd(cmd), .host_wdata(wdata),
        .count_out(count_out), .irq_flag(irq_flag),
        .uf_pulse(uf_pulse), .running(running)
    );

    task automatic check(input string req, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic host(input logic [1:0] c, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; cmd = c; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk); src[idx] = 1'b1;
        @(negedge clk); src = '0;
    endtask

    task automatic raise_trig();
        @(negedge clk); trig = 1'b0;
        repeat (4) @(negedge clk);
        trig = 1'b1;
    endtask

    task automatic t_reset();
        check("R1 count", count_out, 0);
        check("R1 flag", irq_flag, 0);
        check("R1 uf", uf_pulse, 0);
        check("R1 running", running, 0);
    endtask

    task automatic t_loads();
        host(2'd0, 8'd5);
        check("R2 load both", count_out, 5);
        host(2'd1, 8'd9);
        check("R2 reload only keeps count", count_out, 5);
        host(2'd2, 8'h04);
        for (int i = 0; i < 5; i++) pulse(0);
        check("R2 count at zero", count_out, 0);
        check("R4 no flag before uf", irq_flag, 0);
        pulse(0);
        check("R2 new reload used", count_out, 9);
        check("R4 flag set", irq_flag, 1);
        check("R4 uf pulse", uf_pulse, 1);
        @(negedge clk);
        check("R4 uf one cycle", uf_pulse, 0);
    endtask

    task automatic t_divide();
        int ufs;
        host(2'd2, 8'h00);
        host(2'd3, 8'h01);
        host(2'd0, 8'd3);
        host(2'd2, 8'h04);
        ufs = 0;
        for (int i = 1; i <= 8; i++) begin
            pulse(0);
            if (uf_pulse) ufs++;
            check("R3 uf on every 4th", uf_pulse, (i % 4 == 0) ? 1 : 0);
        end
        check("R3 uf total", ufs, 2);
        host(2'd2, 8'h00);
        host(2'd0, 8'd0);
        host(2'd2, 8'h04);
        for (int i = 0; i < 3; i++) begin
            pulse(0);
            check("R3 n=0 uf each pulse", uf_pulse, 1);
            check("R3 n=0 count stays", count_out, 0);
        end
    endtask

    task automatic t_select_and_idle();
        host(2'd2, 8'h00);
        host(2'd0, 8'd20);
        host(2'd2, 8'h06);
        pulse(1);
        pulse(0);
        check("R5 unselected ignored", count_out, 20);
        pulse(2);
        check("R5 selected counts", count_out, 19);
        host(2'd2, 8'h02);
        check("R6 running low", running, 0);
        pulse(2);
        pulse(2);
        check("R6 count holds", count_out, 19);
    endtask

    task automatic t_flag_and_priority();
        host(2'd0, 8'd0);
        host(2'd2, 8'h04);
        pulse(0);
        check("R9 flag set", irq_flag, 1);
        host(2'd3, 8'h00);
        check("R9 bit0 zero ignored", irq_flag, 1);
        host(2'd3, 8'h01);
        check("R9 cleared", irq_flag, 0);
        @(negedge clk); src[0] = 1'b1; wr = 1'b1; cmd = 2'd3; wdata = 8'h01;
        @(negedge clk); src = '0; wr = 1'b0;
        check("R9 set wins over clear", irq_flag, 1);
        host(2'd3, 8'h01);
        @(negedge clk); src[0] = 1'b1; wr = 1'b1; cmd = 2'd0; wdata = 8'd7;
        @(negedge clk); src = '0; wr = 1'b0;
        check("R10 load beats tick", count_out, 7);
        check("R10 no uf", uf_pulse, 0);
        check("R10 no flag", irq_flag, 0);
    endtask

    task automatic t_trigger();
        host(2'd2, 8'h00);
        host(2'd0, 8'd2);
        host(2'd2, 8'h0C);
        pulse(0);
        check("R7 run bit alone idle", running, 0);
        check("R7 count unchanged", count_out, 2);
        raise_trig();
        @(negedge clk);
        @(negedge clk);
        check("R7 not yet after 2 edges", running, 0);
        @(negedge clk);
        check("R7 running after 3 edges", running, 1);
        pulse(0);
        check("R7 counting", count_out, 1);
    endtask

    task automatic t_auto_stop();
        host(2'd2, 8'h00);
        host(2'd0, 8'd1);
        host(2'd2, 8'h1C);
        raise_trig();
        repeat (3) @(negedge clk);
        check("R8 started", running, 1);
        pulse(0);
        pulse(0);
        check("R8 uf seen", uf_pulse, 1);
        check("R8 stopped", running, 0);
        check("R8 reloaded", count_out, 1);
        pulse(0);
        check("R8 frozen", count_out, 1);
        raise_trig();
        repeat (3) @(negedge clk);
        check("R8 restarted", running, 1);
        pulse(0);
        check("R8 counts again", count_out, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_loads();
                t_divide();
                t_select_and_idle();
                t_flag_and_priority();
                t_trigger();
                t_auto_stop();
            end
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule